// File: doc/BRIEF.md
# Single-Precision Register Image Converter

This block moves single-precision values between their 32-bit memory image and a 64-bit register image that uses the double-precision field layout. A direction input picks the operation. A load expands a memory word into the register layout. A store packs a register image back into a memory word. No arithmetic or rounding takes place: the block remaps bits and, on a load, widens the exponent from 8 to 11 bits with a small set of special-case rules.

A load keeps the top bit of the 8-bit exponent as the top bit of the 11-bit exponent. The other seven bits go into the low seven places. The three bits between them are filled according to the class of the value, so zero stays zero and the all-ones code stays all ones. A store is a fixed gather of register bits that pays no attention to special values. The conversion feeds one output register. `out_valid` follows `in_valid` by one cycle, and the direction is captured together with the data.

Top module: `sp_reg_conv`

## Requirements
- R1: On a load (in_dir = 0), the memory word is taken from in_data[31:0]. Its bit 31 appears at out_data[63], its bits 22:0 appear at out_data[51:29], and out_data[28:0] is zero.
- R2: On a load whose memory exponent (bits 30:23) has top bit 1 and low seven bits not all ones, out_data[62:52] is {1'b1, 3'b000, low seven bits}.
- R3: On a load whose memory exponent is 8'hFF, out_data[62:52] is 11'h7FF.
- R4: On a load whose memory exponent has top bit 0 and nonzero low seven bits, out_data[62:52] is {1'b0, 3'b111, low seven bits}.
- R5: On a load whose memory exponent is zero, out_data[62:52] is zero.
- R6: On a store (in_dir = 1), out_data[31:30] equals in_data[63:62] and out_data[29:0] equals in_data[58:29], whatever the values are.
- R7: On a store, out_data[63:32] is zero.
- R8: out_valid is in_valid delayed by exactly one clock, and out_dir is the in_dir that was sampled with valid data.
- R9: While in_valid is low, out_data and out_dir keep their previous values.
- R10: While rst is high, out_valid, out_dir and out_data are cleared to zero on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_dir | input | 1 | 0 = load (expand), 1 = store (compress) |
| in_data | input | 64 | Memory word in bits 31:0 for a load, register image for a store |
| out_valid | output | 1 | Registered result is valid |
| out_dir | output | 1 | Direction captured with the result |
| out_data | output | 64 | Register image after a load, zero-extended memory word after a store |

## Verification
The bench builds the block with its default parameters: a 32-bit memory word with an 8-bit exponent and a 23-bit fraction, and a 64-bit register image with an 11-bit exponent. These values exercise every exponent class on a load: zero, the low half, the high half and all ones, including the boundary codes 0x01, 0x7F, 0x80, 0xFE and 0xFF. On a store, they make the three dropped exponent bits and the dropped low fraction bits visible. Random traffic then mixes both directions with idle cycles, so that the hold behaviour and the one-cycle valid delay are compared against a behavioural model on every clock.

// File: rtl/sp_conv_pkg.sv
package sp_conv_pkg;

    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int REG_W     = 64;
    localparam int MEM_W     = 1 + SP_EXP_W + SP_FRAC_W;

    typedef enum logic {
        DIR_LOAD  = 1'b0,
        DIR_STORE = 1'b1
    } conv_dir_e;

    typedef struct packed {
        logic             sign;
        logic [SP_EXP_W-1:0]  exp;
        logic [SP_FRAC_W-1:0] frac;
    } sp_word_t;

    // Widen an exponent: keep the top bit, fill the middle by class.
    function automatic logic [DP_EXP_W-1:0] widen_exp(input logic [SP_EXP_W-1:0] e);
        logic                  hi;
        logic [SP_EXP_W-2:0]   lo;
        logic [DP_EXP_W-1:0]   w;
        hi = e[SP_EXP_W-1];
        lo = e[SP_EXP_W-2:0];
        w  = '0;
        w[DP_EXP_W-1]   = hi;
        w[SP_EXP_W-2:0] = lo;
        if (hi && (&lo)) begin
            w = '1;
        end else if (!hi && (|lo)) begin
            w[DP_EXP_W-2:SP_EXP_W-1] = '1;
        end
        return w;
    endfunction

endpackage

// File: rtl/sp_expand.sv
module sp_expand
    import sp_conv_pkg::*;
#(
    parameter int EXP_IN_W  = SP_EXP_W,
    parameter int EXP_OUT_W = DP_EXP_W,
    parameter int FRAC_W    = SP_FRAC_W,
    parameter int OUT_W     = REG_W
) (
    input  logic [1+EXP_IN_W+FRAC_W-1:0] mem_i,
    output logic [OUT_W-1:0]             reg_o
);
    localparam int PAD_W = OUT_W - 1 - EXP_OUT_W - FRAC_W;

    sp_word_t             word;
    logic [EXP_OUT_W-1:0] wexp;

    assign word = sp_word_t'(mem_i);
    assign wexp = widen_exp(word.exp);

    generate
        if (PAD_W > 0) begin : g_pad
            assign reg_o = {word.sign, wexp, word.frac, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign reg_o = {word.sign, wexp, word.frac};
        end
    endgenerate

endmodule

// File: rtl/sp_compress.sv
module sp_compress
    import sp_conv_pkg::*;
#(
    parameter int IN_W      = REG_W,
    parameter int WORD_W    = MEM_W,
    parameter int EXP_IN_W  = SP_EXP_W,
    parameter int EXP_REG_W = DP_EXP_W
) (
    input  logic [IN_W-1:0] reg_i,
    output logic [IN_W-1:0] out_o
);
    localparam int SKIP_W = EXP_REG_W - EXP_IN_W;
    localparam int BODY_W = WORD_W - 2;
    localparam int BODY_HI = IN_W - 3 - SKIP_W;
    localparam int BODY_LO = BODY_HI - BODY_W + 1;
    localparam int ZERO_W = IN_W - WORD_W;

    logic [WORD_W-1:0] packed_w;

    assign packed_w = {reg_i[IN_W-1 -: 2], reg_i[BODY_HI:BODY_LO]};
    assign out_o    = {{ZERO_W{1'b0}}, packed_w};

    logic unused_bits;
    assign unused_bits = ^{reg_i[IN_W-3:BODY_HI+1], reg_i[BODY_LO-1:0]};

endmodule

// File: rtl/sp_out_stage.sv
module sp_out_stage #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         v_i,
    input  logic         dir_i,
    input  logic [W-1:0] d_i,
    output logic         v_o,
    output logic         dir_o,
    output logic [W-1:0] d_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            v_o   <= 1'b0;
            dir_o <= 1'b0;
            d_o   <= '0;
        end else begin
            v_o <= v_i;
            if (v_i) begin
                dir_o <= dir_i;
                d_o   <= d_i;
            end
        end
    end

    a_r8_valid_delay: assert property (@(posedge clk) disable iff (rst)
        v_i |=> v_o);
    a_r8_idle_delay: assert property (@(posedge clk) disable iff (rst)
        !v_i |=> !v_o);
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !v_i |=> ($stable(d_o) && $stable(dir_o)));

endmodule

// File: rtl/sp_reg_conv.sv
module sp_reg_conv
    import sp_conv_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int WORD_W = MEM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_dir,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_dir,
    output logic [DATA_W-1:0] out_data
);
    localparam int EXP_HI = DATA_W - 2;
    localparam int EXP_LO = DATA_W - 1 - DP_EXP_W;

    conv_dir_e         dir;
    logic [DATA_W-1:0] load_img;
    logic [DATA_W-1:0] store_img;
    logic [DATA_W-1:0] next_img;

    assign dir = conv_dir_e'(in_dir);

    sp_expand #(
        .EXP_IN_W (SP_EXP_W),
        .EXP_OUT_W(DP_EXP_W),
        .FRAC_W   (SP_FRAC_W),
        .OUT_W    (DATA_W)
    ) u_expand (
        .mem_i(in_data[WORD_W-1:0]),
        .reg_o(load_img)
    );

    sp_compress #(
        .IN_W     (DATA_W),
        .WORD_W   (WORD_W),
        .EXP_IN_W (SP_EXP_W),
        .EXP_REG_W(DP_EXP_W)
    ) u_compress (
        .reg_i(in_data),
        .out_o(store_img)
    );

    always_comb begin
        case (dir)
            DIR_STORE: next_img = store_img;
            default:   next_img = load_img;
        endcase
    end

    sp_out_stage #(.W(DATA_W)) u_stage (
        .clk  (clk),
        .rst  (rst),
        .v_i  (in_valid),
        .dir_i(in_dir),
        .d_i  (next_img),
        .v_o  (out_valid),
        .dir_o(out_dir),
        .d_o  (out_data)
    );

    a_r7_store_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_dir == DIR_STORE) |-> (out_data[DATA_W-1:WORD_W] == '0));
    a_r1_load_low_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_dir == DIR_LOAD) |-> (out_data[DATA_W-2-DP_EXP_W-SP_FRAC_W:0] == '0));
    a_r3_all_ones: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_dir && (&in_data[WORD_W-2:SP_FRAC_W]))
        |=> (&out_data[EXP_HI:EXP_LO]));
    a_r5_zero_exp: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_dir && (in_data[WORD_W-2:SP_FRAC_W] == '0))
        |=> (out_data[EXP_HI:EXP_LO] == '0));
    a_r6_sign_kept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dir) |=> (out_data[WORD_W-1] == $past(in_data[DATA_W-1])));

endmodule

// File: tb/test_sp_reg_conv.sv
`timescale 1ns/1ps
module test_sp_reg_conv;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_dir = 1'b0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic        out_dir;
    logic [63:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sp_reg_conv i_sp_reg_conv (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dir(in_dir),
        .in_data(in_data), .out_valid(out_valid), .out_dir(out_dir),
        .out_data(out_data)
    );

    // Behavioural reference
    logic        m_valid = 0;
    logic        m_dir = 0;
    logic [63:0] m_data = '0;
    string       m_tag = "R10";
    bit          m_rst = 1;

    function automatic logic [63:0] ref_load(input logic [31:0] w);
        int e;
        int de;
        e = int'(w[30:23]);
        if (e == 0) de = 0;
        else if (e == 255) de = 2047;
        else de = e + 896;
        return {w[31], 11'(de), w[22:0], 29'd0};
    endfunction

    function automatic string exp_tag(input logic [31:0] w);
        int e;
        e = int'(w[30:23]);
        if (e == 0) return "R5";
        if (e == 255) return "R3";
        if (e < 128) return "R4";
        return "R2";
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_valid <= 0; m_dir <= 0; m_data <= '0; m_rst <= 1; m_tag <= "R10";
        end else begin
            m_rst <= 0;
            m_valid <= in_valid;
            if (in_valid) begin
                m_dir <= in_dir;
                if (in_dir) begin
                    m_data <= {32'd0, in_data[63], in_data[62], in_data[58:29]};
                    m_tag <= "R6";
                end else begin
                    m_data <= ref_load(in_data[31:0]);
                    m_tag <= exp_tag(in_data[31:0]);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (cyc > 0 && !finished) begin
            if (m_rst) begin
                chk(out_valid === 1'b0 && out_dir === 1'b0, "R10", {62'd0, out_dir, out_valid}, 64'd0);
                chk(out_data === 64'd0, "R10", out_data, 64'd0);
            end else begin
                chk(out_valid === m_valid, "R8", {63'd0, out_valid}, {63'd0, m_valid});
                if (!m_valid) begin
                    chk(out_data === m_data && out_dir === m_dir, "R9", out_data, m_data);
                end else if (m_dir) begin
                    chk(out_dir === 1'b1, "R8", {63'd0, out_dir}, 64'd1);
                    chk(out_data[31:0] === m_data[31:0], "R6", out_data, m_data);
                    chk(out_data[63:32] === 32'd0, "R7", out_data, m_data);
                end else begin
                    chk(out_dir === 1'b0, "R8", {63'd0, out_dir}, 64'd0);
                    chk({out_data[63], out_data[51:0]} === {m_data[63], m_data[51:0]}, "R1", out_data, m_data);
                    chk(out_data[62:52] === m_data[62:52], m_tag, out_data, m_data);
                end
            end
        end
    end

    task automatic send(input bit v, input bit d, input logic [63:0] x);
        @(negedge clk);
        in_valid = v; in_dir = d; in_data = x;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // Load exponent classes and boundaries (R2 R3 R4 R5)
        send(1, 0, 64'h0000_0000_0000_0000);
        send(1, 0, 64'hDEAD_BEEF_8000_0001);
        send(1, 0, 64'h0000_0000_0080_0000);
        send(1, 0, 64'h0000_0000_3F80_0000);
        send(1, 0, 64'h0000_0000_4000_0000);
        send(1, 0, 64'h0000_0000_7F7F_FFFF);
        send(1, 0, 64'h0000_0000_7F80_0000);
        send(1, 0, 64'h0000_0000_FFC0_0001);
        send(1, 0, 64'h0000_0000_007F_FFFF);
        // Stores, including specials (R6 R7)
        send(1, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        send(1, 1, 64'h47F0_0000_0000_0000);
        send(1, 1, 64'h8000_0000_1FFF_FFFF);
        send(1, 1, 64'h3C7F_FFFF_E000_0000);
        // Idle with changing data (R9)
        send(0, 1, 64'h1234_5678_9ABC_DEF0);
        send(0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        send(1, 0, 64'h0000_0000_C0A0_0000);
        send(0, 1, 64'h0);
        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [63:0] x;
            int sel;
            x = {$urandom, $urandom};
            sel = int'($urandom % 4);
            if (sel == 0) x[30:23] = 8'hFF;
            if (sel == 1) x[30:23] = 8'h00;
            send(($urandom % 4) != 0, $urandom % 2, x);
        end
        // Reset mid-stream (R10)
        send(1, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        rst = 1;
        send(1, 0, 64'h0000_0000_FFFF_FFFF);
        send(0, 0, 64'h0);
        rst = 0;
        send(0, 0, 64'h0);
        send(0, 0, 64'h0);
        @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            finish_run();
        end
    end

endmodule